// File: doc/BRIEF.md
# Monochrome Bitmap Video Scanner

This block scans a one-bit-per-pixel frame buffer held in shared RAM and turns it into a 400x300 monochrome picture. It runs on the 20 MHz dot clock. It keeps horizontal and vertical position counters and decodes sync and blanking from them. It issues one byte read per eight dots and shifts each returned byte out one pixel per dot. Each stored row is shown on two consecutive scan lines, so 600 lines are scanned for 300 rows. A row holds 48 bytes, so the last 16 visible dots of each line come out dark.

The same counter also produces the processor clock, one eighth of the dot rate. This places every video read in the half of each processor cycle when the processor does not use the bus. A halt input stops the processor clock in that low half, so other bus masters can use the memory while the display keeps running at full rate.

Top module: `mono_video_scan`

## Requirements
- R1: A line lasts 528 dots (dot 0..527). `hsync` is high on dots 420..483 and low elsewhere.
- R2: A frame lasts V_VIS+28 lines (628 by default). The line number advances only when dot 527 ends. `vsync` is high on lines V_VIS+1..V_VIS+4 and low elsewhere.
- R3: `blank` is low exactly on dots 0..399 of lines 0..V_VIS-1, and high everywhere else.
- R4: `rd_en` is a one-dot strobe. It fires on dot 8k+4 (k = 0..46) for column k+1 of the current line, and on dot 524 for column 0 of the next line, where the next line after the last is line 0. It stays low when the column is 48 or more, or when the line is V_VIS or more.
- R5: While `rd_en` is high, `rd_addr` = 0xC000 + (line/2)*48 + column. The default frame spans 0xC000..0xF83F.
- R6: The RAM returns `rd_data` on the dot after the strobe. That byte is shown over the 8 dots of its column, most significant bit on dot 8*column.
- R7: `pixel` is 0 while `blank` is high, and on dots 384..399. After reset it is also 0 for dots 0..7 of the first line.
- R8: When running, `cpu_clk` is high on dots 8k..8k+3 and low on dots 8k+4..8k+7. Every read strobe therefore falls while `cpu_clk` is low.
- R9: `halt` is sampled at the end of dot 8k+7. If it is high there, `cpu_clk` stays low for the whole next group. A change of `halt` at any other dot has no effect until that sample point, so a high phase is never cut short.
- R10: Counters, syncs, blanking, read strobes, addresses and pixels do not depend on `halt`.
- R11: While `rst_n` is low, both counters hold at zero. In that state `hsync`, `vsync`, `blank`, `pixel`, `rd_en` and `cpu_clk` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Request to park the processor clock low |
| rd_data | input | 8 | Byte returned by RAM one dot after the strobe |
| rd_en | output | 1 | Frame-buffer read strobe |
| rd_addr | output | 16 | Frame-buffer byte address |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | High outside the visible area |
| pixel | output | 1 | Serialized pixel value |
| cpu_clk | output | 1 | Processor clock, dot clock divided by 8 |

## Verification
Two events share the last dot of every group: the halt sample that decides the next processor phase, and the shift-register load. On dot 527 the line and frame wrap also land on that dot. The bench drives `halt` in segments 13 dots long, which is coprime to the 8-dot group. Over the run, halt edges therefore fall on every slot of the group, including the load dot, the fetch dot, and the wrap dot. A dot-by-dot reference model checks `cpu_clk`, every strobe, address and pixel against the requirements on each cycle. Any leak of halt into the video path, or of the load into the clock divide, is reported.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
    localparam int unsigned GROUP_DOTS = 8;
    localparam int unsigned GROUP_BITS = 3;

    localparam logic [2:0] SLOT_FETCH   = 3'd4;
    localparam logic [2:0] SLOT_CAPTURE = 3'd5;
    localparam logic [2:0] SLOT_LAST    = 3'd7;

    typedef logic [7:0] vbyte_t;

    typedef struct packed {
        logic   pend;
        vbyte_t hold;
        vbyte_t sh;
    } shift_state_t;
endpackage

// File: rtl/vscan_timing.sv
module vscan_timing #(
    parameter int H_VIS  = 400,
    parameter int H_FP   = 20,
    parameter int H_SYNC = 64,
    parameter int H_BP   = 44,
    parameter int V_VIS  = 600,
    parameter int V_FP   = 1,
    parameter int V_SYNC = 4,
    parameter int V_BP   = 23,
    localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
    localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
    localparam int HW    = $clog2(H_TOT),
    localparam int VW    = $clog2(V_TOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_o,
    output logic [VW-1:0] v_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          blank_o
);
    localparam logic [HW-1:0] H_LAST   = HW'(H_TOT - 1);
    localparam logic [VW-1:0] V_LAST   = VW'(V_TOT - 1);
    localparam logic [HW-1:0] HS_START = HW'(H_VIS + H_FP);
    localparam logic [HW-1:0] HS_END   = HW'(H_VIS + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_START = VW'(V_VIS + V_FP);
    localparam logic [VW-1:0] VS_END   = VW'(V_VIS + V_FP + V_SYNC);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.h == H_LAST) begin
            pos_d.h = '0;
            pos_d.v = (pos_q.v == V_LAST) ? '0 : pos_q.v + 1'b1;
        end else begin
            pos_d.h = pos_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign h_o     = pos_q.h;
    assign v_o     = pos_q.v;
    assign hsync_o = (pos_q.h >= HS_START) && (pos_q.h < HS_END);
    assign vsync_o = (pos_q.v >= VS_START) && (pos_q.v < VS_END);
    assign blank_o = !((pos_q.h < HW'(H_VIS)) && (pos_q.v < VW'(V_VIS)));

    p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.h == H_LAST) |=> (pos_q.h == '0));

    p_vhold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.h != H_LAST) |=> $stable(pos_q.v));
endmodule

// File: rtl/vscan_fetch.sv
module vscan_fetch
    import vscan_pkg::*;
#(
    parameter int H_TOT       = 528,
    parameter int V_TOT       = 628,
    parameter int V_VIS       = 600,
    parameter int ROW_BYTES   = 48,
    parameter int FB_BASE     = 'hC000,
    parameter int REPEAT_LOG2 = 1,
    parameter int AW          = 16,
    parameter int HW          = 10,
    parameter int VW          = 10
) (
    input  logic [HW-1:0] h_i,
    input  logic [VW-1:0] v_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o
);
    localparam int LAST_GROUP = H_TOT / int'(GROUP_DOTS) - 1;

    int grp, fcol, fline;

    always_comb begin
        grp = int'(h_i >> GROUP_BITS);
        if (grp == LAST_GROUP) begin
            fcol  = 0;
            fline = (int'(v_i) == V_TOT - 1) ? 0 : int'(v_i) + 1;
        end else begin
            fcol  = grp + 1;
            fline = int'(v_i);
        end
        rd_en_o   = (h_i[GROUP_BITS-1:0] == SLOT_FETCH)
                    && (fcol < ROW_BYTES) && (fline < V_VIS);
        rd_addr_o = AW'(FB_BASE + (fline >>> REPEAT_LOG2) * ROW_BYTES + fcol);
    end
endmodule

// File: rtl/vscan_shift.sv
module vscan_shift
    import vscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] slot_i,
    input  logic       fetch_i,
    input  vbyte_t     data_i,
    input  logic       active_i,
    output logic       pixel_o
);
    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (slot_i == SLOT_FETCH)   st_d.pend = fetch_i;
        if (slot_i == SLOT_CAPTURE) st_d.hold = st_q.pend ? data_i : '0;
        if (slot_i == SLOT_LAST)    st_d.sh   = st_q.hold;
        else                        st_d.sh   = {st_q.sh[6:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pixel_o = st_q.sh[7] & active_i;

    p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i != SLOT_LAST) |=> (st_q.sh[0] == 1'b0));
endmodule

// File: rtl/vscan_clkdiv.sv
module vscan_clkdiv
    import vscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] slot_i,
    input  logic       halt_i,
    output logic       cpu_clk_o
);
    logic run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (slot_i == SLOT_LAST) run_d = !halt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    assign cpu_clk_o = run_q & ~slot_i[2];

    p_high_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_o) |=> cpu_clk_o);
endmodule

// File: rtl/mono_video_scan.sv
module mono_video_scan
    import vscan_pkg::*;
#(
    parameter int H_VIS       = 400,
    parameter int H_FP        = 20,
    parameter int H_SYNC      = 64,
    parameter int H_BP        = 44,
    parameter int V_VIS       = 600,
    parameter int V_FP        = 1,
    parameter int V_SYNC      = 4,
    parameter int V_BP        = 23,
    parameter int ROW_BYTES   = 48,
    parameter int FB_BASE     = 'hC000,
    parameter int REPEAT_LOG2 = 1,
    parameter int AW          = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    input  logic [7:0]    rd_data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          hsync,
    output logic          vsync,
    output logic          blank,
    output logic          pixel,
    output logic          cpu_clk
);
    localparam int H_TOT    = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOT    = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HW       = $clog2(H_TOT);
    localparam int VW       = $clog2(V_TOT);
    localparam int FB_BYTES = (V_VIS >>> REPEAT_LOG2) * ROW_BYTES;

    logic [HW-1:0] h;
    logic [VW-1:0] v;
    logic [2:0]    slot;

    vscan_timing #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .h_o(h), .v_o(v),
        .hsync_o(hsync), .vsync_o(vsync), .blank_o(blank)
    );

    assign slot = h[GROUP_BITS-1:0];

    vscan_fetch #(
        .H_TOT(H_TOT), .V_TOT(V_TOT), .V_VIS(V_VIS), .ROW_BYTES(ROW_BYTES),
        .FB_BASE(FB_BASE), .REPEAT_LOG2(REPEAT_LOG2), .AW(AW), .HW(HW), .VW(VW)
    ) u_fetch (
        .h_i(h), .v_i(v), .rd_en_o(rd_en), .rd_addr_o(rd_addr)
    );

    vscan_shift u_shift (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .fetch_i(rd_en),
        .data_i(rd_data), .active_i(!blank), .pixel_o(pixel)
    );

    vscan_clkdiv u_clkdiv (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .halt_i(halt),
        .cpu_clk_o(cpu_clk)
    );

    p_fetch_low_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !cpu_clk);

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    p_addr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ((rd_addr >= AW'(FB_BASE)) && (rd_addr < AW'(FB_BASE + FB_BYTES))));

    p_vsync_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> blank);
endmodule

// File: tb/test_mono_video_scan.sv
module test_mono_video_scan;
    localparam int HV = 400, HFP = 20, HS = 64, HB = 44;
    localparam int VV = 40,  VFP = 1,  VS = 4,  VB = 3;
    localparam int HT = HV + HFP + HS + HB;
    localparam int VT = VV + VFP + VS + VB;
    localparam int COLS = 48;
    localparam int BASE = 'hC000;
    localparam int RUN = 2 * HT * VT + 1200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic        hsync, vsync, blank, pixel, cpu_clk;

    mono_video_scan #(
        .H_VIS(HV), .H_FP(HFP), .H_SYNC(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VFP), .V_SYNC(VS), .V_BP(VB)
    ) i_mono_video_scan (
        .clk(clk), .rst_n(rst_n), .halt(halt), .rd_data(rd_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .hsync(hsync), .vsync(vsync),
        .blank(blank), .pixel(pixel), .cpu_clk(cpu_clk)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13) ^ (a >> 4) ^ 'h5A);
    endfunction

    // RAM model: request seen mid-dot, data valid on the following dot
    logic        ram_req = 1'b0;
    logic [15:0] ram_addr = 16'h0;
    always @(negedge clk) begin
        ram_req  <= rd_en;
        ram_addr <= rd_addr;
    end
    always @(posedge clk) if (ram_req) rd_data <= pat(int'(ram_addr));

    int  checks = 0, failures = 0;
    bit  done = 1'b0;
    int  hh = 0, vv = 0, since = 0;
    bit  mrun = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            if (failures <= 30)
                $display("FAIL %s %s actual=%0d expected=%0d (dot %0d line %0d)",
                         req, what, act, exp, hh, vv);
        end
    endtask

    task automatic compare_all();
        bit vis;
        int col, grp, fcol, fline, ea;
        bit en_exp, px_exp;
        logic [7:0] b;
        vis = (hh < HV) && (vv < VV);
        chk("R1", "hsync", int'(hsync), int'(hh >= HV + HFP && hh < HV + HFP + HS));
        chk("R2", "vsync", int'(vsync), int'(vv >= VV + VFP && vv < VV + VFP + VS));
        chk("R3", "blank", int'(blank), int'(!vis));
        chk(mrun ? "R8" : "R9", "cpu_clk", int'(cpu_clk), int'(mrun && (hh % 8) < 4));
        // expected fetch
        grp = hh / 8;
        if (grp == HT / 8 - 1) begin
            fcol = 0; fline = (vv == VT - 1) ? 0 : vv + 1;
        end else begin
            fcol = grp + 1; fline = vv;
        end
        en_exp = ((hh % 8) == 4) && fcol < COLS && fline < VV;
        chk(halt ? "R10" : "R4", "rd_en", int'(rd_en), int'(en_exp));
        if (en_exp) begin
            ea = BASE + (fline / 2) * COLS + fcol;
            chk("R5", "rd_addr", int'(rd_addr), ea);
        end
        // expected pixel
        col = hh / 8;
        if (!vis || col >= COLS || since < 8) begin
            chk("R7", "pixel", int'(pixel), 0);
        end else begin
            b = pat(BASE + (vv / 2) * COLS + col);
            px_exp = b[7 - (hh % 8)];
            chk(mrun ? "R6" : "R10", "pixel", int'(pixel), int'(px_exp));
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R11", "hsync", int'(hsync), 0);
            chk("R11", "vsync", int'(vsync), 0);
            chk("R11", "blank", int'(blank), 0);
            chk("R11", "pixel", int'(pixel), 0);
            chk("R11", "rd_en", int'(rd_en), 0);
            chk("R11", "cpu_clk", int'(cpu_clk), 0);
        end
        rst_n = 1'b1;
        for (int cyc = 0; cyc < RUN; cyc++) begin
            @(posedge clk);
            if ((hh % 8) == 7) mrun = !halt;
            if (hh == HT - 1) begin
                hh = 0;
                vv = (vv == VT - 1) ? 0 : vv + 1;
            end else begin
                hh++;
            end
            since++;
            @(negedge clk);
            compare_all();
            begin
                int seg;
                seg = cyc / 13;
                halt = ((seg % 4) == 1) || ((seg % 7) == 3);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * (RUN + 2000));
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule